// File: doc/BRIEF.md
# Zero-Suppression Trigger Window Controller

This block watches a stream of signed ADC samples, one per clock, and passes on only the samples that fall inside a window around a trigger event. All other samples are dropped before they reach the downstream FIFO. Two threshold units inspect every raw sample. Each unit has its own threshold, its own direction (fire above or fire below) and its own mode (fire on every qualifying sample, or only on the sample where the data first qualifies). The hits of both units, together with a set of external trigger bits, pass through a per-source enable mask and are ORed into one trigger per sample.

A delay line lets the window open a programmable number of samples (the precursor) before the trigger sample. The window stays open for a programmable number of samples (the length) after the trigger. When retriggering is enabled, a trigger inside an open window pushes the end out again. A sample-aligned gate bit can suppress writes without changing the window timing. Samples leave the block on a write port that carries a valid strobe and first-sample and last-sample markers. Configuration is captured through a load strobe and is accepted only while nothing is being written.

Top module: `zstw_top`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first window, `wr_valid_o`, `wr_sop_o` and `wr_eop_o` are low.
- R2: A unit whose direction bit is 1 fires on a sample strictly greater than its threshold. A unit whose direction bit is 0 fires on a sample strictly less than its threshold. Both comparisons are two's complement, so a sample equal to the threshold never fires.
- R3: In level mode (mode bit 0) a unit fires on every qualifying sample. In edge mode (mode bit 1) it fires only on a qualifying sample whose predecessor did not qualify. The sample before the first one after reset counts as qualifying, so an edge-mode unit never fires on two consecutive samples.
- R4: The trigger for a sample is the OR of the enabled sources. Mask bit 0 enables unit 0, mask bit 1 enables unit 1, and mask bit 2+i enables `ext_trig_i[i]`, which is sampled together with the sample it belongs to.
- R5: An accepted trigger on sample n opens the window over samples n-P through n+L, where P is the loaded precursor clamped to MAX_PRE and L is the loaded length. A sample presented at clock edge k appears on `wr_data_o` after edge k+1+P.
- R6: With retrigger off, a trigger on a sample at or before the current window end is ignored. An edge-mode packet that nothing else disturbs is therefore exactly P+L+1 samples long.
- R7: With retrigger on, every trigger inside an open window moves the window end to L samples after that trigger.
- R8: If a new window's precursor reaches back into samples that are already written or still queued, the precursor is clipped. No sample is written twice, and the new window continues the running packet without a gap. Samples from before reset are never written.
- R9: `gate_en_i` travels with its sample. A sample whose gate bit is low is not written (valid, start and end markers all low), and the window timing is unchanged.
- R10: `wr_sop_o` marks the first sample of a packet and `wr_eop_o` marks the last. A one-sample packet carries both markers. A marker appears only together with `wr_valid_o`.
- R11: `cfg_load_i` captures all configuration inputs at a clock edge only if no sample is written at that edge and no window remains pending. Otherwise the load is discarded and the previous settings stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | SAMPLE_W | Signed raw sample, one per clock |
| gate_en_i | input | 1 | Write enable aligned with `smp_i` |
| ext_trig_i | input | N_EXT | External trigger bits aligned with `smp_i` |
| cfg_load_i | input | 1 | Request to capture configuration |
| cfg_thr0_i | input | SAMPLE_W | Signed threshold, unit 0 |
| cfg_thr1_i | input | SAMPLE_W | Signed threshold, unit 1 |
| cfg_above_i | input | 2 | Per-unit direction, 1 = above |
| cfg_edge_i | input | 2 | Per-unit mode, 1 = edge |
| cfg_mask_i | input | N_EXT+2 | Source enable mask |
| cfg_pre_i | input | clog2(MAX_PRE+1) | Precursor sample count |
| cfg_len_i | input | LEN_W | Post-trigger sample count |
| cfg_retrig_i | input | 1 | Retrigger enable |
| wr_valid_o | output | 1 | Sample written to FIFO |
| wr_data_o | output | SAMPLE_W | Written sample |
| wr_sop_o | output | 1 | First sample of packet |
| wr_eop_o | output | 1 | Last sample of packet |

## Verification
The bench builds the block with SAMPLE_W=8, MAX_PRE=6, LEN_W=4 and N_EXT=7. With these values the 3-bit precursor field can carry 7, which is above the delay depth, so the clamp is reached. The short lengths close windows every few samples, so clipped precursors, merged packets and retrigger reloads occur often in random traffic. Narrow 8-bit random data crosses the thresholds constantly, and the bench also drives the equality case, single-sample packets and loads attempted during a window as directed cases.

// File: rtl/zstw_pkg.sv
package zstw_pkg;

  localparam int N_UNIT = 2;

  typedef enum logic {
    CMP_BELOW = 1'b0,
    CMP_ABOVE = 1'b1
  } cmp_dir_e;

  typedef enum logic {
    HIT_LEVEL = 1'b0,
    HIT_EDGE  = 1'b1
  } hit_mode_e;

endpackage

// File: rtl/zstw_decide.sv
module zstw_decide #(
  parameter int SAMPLE_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic signed [SAMPLE_W-1:0] thr_i,
  input  zstw_pkg::cmp_dir_e         dir_i,
  input  zstw_pkg::hit_mode_e        mode_i,
  output logic                       hit_o
);
  import zstw_pkg::*;

  logic sat;
  logic hit_d;
  logic sat_prev_q;
  logic hit_q;
  logic edge_q;

  // Qualification of the current sample; equality never qualifies.
  always_comb begin
    if (dir_i == CMP_ABOVE) sat = (smp_i > thr_i);
    else                    sat = (smp_i < thr_i);
  end

  always_comb begin
    if (mode_i == HIT_EDGE) hit_d = sat && !sat_prev_q;
    else                    hit_d = sat;
  end

  // Predecessor resets to "qualifying" so no edge is seen on the first sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_prev_q <= 1'b1;
      hit_q      <= 1'b0;
      edge_q     <= 1'b0;
    end else begin
      sat_prev_q <= sat;
      hit_q      <= hit_d;
      edge_q     <= (mode_i == HIT_EDGE);
    end
  end

  assign hit_o = hit_q;

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && edge_q) |=> !(hit_q && edge_q)); // R3

endmodule

// File: rtl/zstw_delay.sv
module zstw_delay #(
  parameter int W     = 15,
  parameter int DEPTH = 32,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     din_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     tap_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(DEPTH);

  // stage_q[j] holds the entry registered j clocks before the newest one.
  logic [W-1:0] stage_q [DEPTH+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j <= DEPTH; j++) stage_q[j] <= '0;
    end else begin
      stage_q[0] <= din_i;
      for (int j = 1; j <= DEPTH; j++) stage_q[j] <= stage_q[j-1];
    end
  end

  always_comb begin
    if (sel_i > LAST) tap_o = stage_q[DEPTH];
    else              tap_o = stage_q[sel_i];
  end

endmodule

// File: rtl/zstw_window.sv
module zstw_window #(
  parameter int PRE_W = 6,
  parameter int LEN_W = 12,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             retrig_i,
  output logic             emit_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic             idle_o
);
  // rem_q counts samples still owed to the window, starting with the one
  // currently at the delay tap. A trigger sample lies P samples ahead of the
  // tap, so the window still covers it in trigger time while rem_q > P.
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             covered;
  logic             in_window;
  logic             accept;

  always_comb begin
    covered   = (rem_q != '0);
    in_window = (rem_q > CNT_W'(pre_i));
    accept    = trig_i && (retrig_i || !in_window);
    emit_o    = accept || covered;
    if (accept)       rem_d = CNT_W'(pre_i) + CNT_W'(len_i);
    else if (covered) rem_d = rem_q - CNT_W'(1);
    else              rem_d = '0;
    sop_o  = emit_o && !covered;
    eop_o  = emit_o && (rem_d == '0);
    idle_o = !emit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  AST_NO_RETRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_i && (rem_q > CNT_W'(pre_i))) |=> (rem_q == $past(rem_q) - CNT_W'(1))); // R6

  AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && retrig_i) |=> (rem_q == $past(CNT_W'(pre_i) + CNT_W'(len_i)))); // R7

endmodule

// File: rtl/zstw_top.sv
module zstw_top #(
  parameter  int SAMPLE_W = 14,
  parameter  int MAX_PRE  = 32,
  parameter  int LEN_W    = 12,
  parameter  int N_EXT    = 7,
  localparam int PRE_W    = $clog2(MAX_PRE + 1),
  localparam int N_SRC    = N_EXT + zstw_pkg::N_UNIT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       gate_en_i,
  input  logic [N_EXT-1:0]           ext_trig_i,
  input  logic                       cfg_load_i,
  input  logic signed [SAMPLE_W-1:0] cfg_thr0_i,
  input  logic signed [SAMPLE_W-1:0] cfg_thr1_i,
  input  logic [1:0]                 cfg_above_i,
  input  logic [1:0]                 cfg_edge_i,
  input  logic [N_SRC-1:0]           cfg_mask_i,
  input  logic [PRE_W-1:0]           cfg_pre_i,
  input  logic [LEN_W-1:0]           cfg_len_i,
  input  logic                       cfg_retrig_i,
  output logic                       wr_valid_o,
  output logic signed [SAMPLE_W-1:0] wr_data_o,
  output logic                       wr_sop_o,
  output logic                       wr_eop_o
);
  import zstw_pkg::*;

  localparam int               CNT_W   = $clog2(MAX_PRE + (1 << LEN_W));
  localparam int               DLY_W   = SAMPLE_W + 1;
  localparam logic [PRE_W-1:0] PRE_CAP = PRE_W'(MAX_PRE);

  // Captured configuration
  logic signed [SAMPLE_W-1:0] thr_q  [N_UNIT];
  cmp_dir_e                   dir_q  [N_UNIT];
  hit_mode_e                  mode_q [N_UNIT];
  logic [N_SRC-1:0]           mask_q;
  logic [PRE_W-1:0]           pre_q;
  logic [LEN_W-1:0]           len_q;
  logic                       retrig_q;

  logic                       win_idle;
  logic                       load_en;
  logic [PRE_W-1:0]           pre_capped;
  logic signed [SAMPLE_W-1:0] thr_in [N_UNIT];

  // Trigger path
  logic [N_UNIT-1:0] unit_hit;
  logic [N_EXT-1:0]  ext_q;
  logic [N_SRC-1:0]  src_vec;
  logic              trig;

  // Data path
  logic [DLY_W-1:0]           tap;
  logic                       tap_gate;
  logic signed [SAMPLE_W-1:0] tap_data;
  logic                       win_emit;
  logic                       win_sop;
  logic                       win_eop;
  logic                       wr_en;

  logic                       wr_valid_q;
  logic signed [SAMPLE_W-1:0] wr_data_q;
  logic                       wr_sop_q;
  logic                       wr_eop_q;

  // ---------------- configuration capture ----------------
  always_comb begin
    thr_in[0]  = cfg_thr0_i;
    thr_in[1]  = cfg_thr1_i;
    pre_capped = (cfg_pre_i > PRE_CAP) ? PRE_CAP : cfg_pre_i;
    load_en    = cfg_load_i && win_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < N_UNIT; u++) begin
        thr_q[u]  <= '0;
        dir_q[u]  <= CMP_BELOW;
        mode_q[u] <= HIT_LEVEL;
      end
      mask_q   <= '0;
      pre_q    <= '0;
      len_q    <= '0;
      retrig_q <= 1'b0;
    end else if (load_en) begin
      for (int u = 0; u < N_UNIT; u++) begin
        thr_q[u]  <= thr_in[u];
        dir_q[u]  <= cmp_dir_e'(cfg_above_i[u]);
        mode_q[u] <= hit_mode_e'(cfg_edge_i[u]);
      end
      mask_q   <= cfg_mask_i;
      pre_q    <= pre_capped;
      len_q    <= cfg_len_i;
      retrig_q <= cfg_retrig_i;
    end
  end

  // ---------------- decision units ----------------
  for (genvar g = 0; g < N_UNIT; g++) begin : g_unit
    zstw_decide #(
      .SAMPLE_W (SAMPLE_W)
    ) u_decide (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (smp_i),
      .thr_i  (thr_q[g]),
      .dir_i  (dir_q[g]),
      .mode_i (mode_q[g]),
      .hit_o  (unit_hit[g])
    );
  end

  // External bits are registered alongside the unit hits of the same sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= ext_trig_i;
  end

  always_comb begin
    src_vec = {ext_q, unit_hit};
    trig    = |(src_vec & mask_q);
  end

  // ---------------- precursor delay ----------------
  zstw_delay #(
    .W     (DLY_W),
    .DEPTH (MAX_PRE),
    .SEL_W (PRE_W)
  ) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .din_i ({gate_en_i, smp_i}),
    .sel_i (pre_q),
    .tap_o (tap)
  );

  always_comb begin
    tap_gate = tap[DLY_W-1];
    tap_data = tap[SAMPLE_W-1:0];
  end

  // ---------------- window control ----------------
  zstw_window #(
    .PRE_W (PRE_W),
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig),
    .pre_i    (pre_q),
    .len_i    (len_q),
    .retrig_i (retrig_q),
    .emit_o   (win_emit),
    .sop_o    (win_sop),
    .eop_o    (win_eop),
    .idle_o   (win_idle)
  );

  // ---------------- write port ----------------
  always_comb wr_en = win_emit && tap_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_q <= 1'b0;
      wr_sop_q   <= 1'b0;
      wr_eop_q   <= 1'b0;
    end else begin
      wr_valid_q <= wr_en;
      wr_sop_q   <= win_sop && tap_gate;
      wr_eop_q   <= win_eop && tap_gate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_data_q <= '0;
    else if (wr_en) wr_data_q <= tap_data;
  end

  assign wr_valid_o = wr_valid_q;
  assign wr_data_o  = wr_data_q;
  assign wr_sop_o   = wr_sop_q;
  assign wr_eop_o   = wr_eop_q;

  AST_SOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sop_o |-> wr_valid_o); // R10

  AST_EOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eop_o |-> wr_valid_o); // R10

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !win_idle |=> ($stable(pre_q) && $stable(len_q) && $stable(mask_q) && $stable(retrig_q))); // R11

  AST_PRE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_i && win_idle |=> (pre_q <= PRE_CAP)); // R5

endmodule

// File: tb/zstw_top_test.sv
module zstw_top_test;
  localparam int SW = 8;
  localparam int MP = 6;
  localparam int LW = 4;
  localparam int NE = 7;
  localparam int NS = NE + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n;
  logic signed [SW-1:0] s_x;
  logic                 s_g;
  logic [NE-1:0]        s_ext;
  logic                 s_load;
  logic signed [SW-1:0] c_thr0, c_thr1;
  logic [1:0]           c_above, c_edge;
  logic [NS-1:0]        c_mask;
  logic [2:0]           c_pre;
  logic [LW-1:0]        c_len;
  logic                 c_rt;

  logic                 wr_valid, wr_sop, wr_eop;
  logic signed [SW-1:0] wr_data;

  zstw_top #(.SAMPLE_W(SW), .MAX_PRE(MP), .LEN_W(LW), .N_EXT(NE)) uut (
    .clk(clk), .rst_n(rst_n), .smp_i(s_x), .gate_en_i(s_g), .ext_trig_i(s_ext),
    .cfg_load_i(s_load), .cfg_thr0_i(c_thr0), .cfg_thr1_i(c_thr1),
    .cfg_above_i(c_above), .cfg_edge_i(c_edge), .cfg_mask_i(c_mask),
    .cfg_pre_i(c_pre), .cfg_len_i(c_len), .cfg_retrig_i(c_rt),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .wr_sop_o(wr_sop), .wr_eop_o(wr_eop)
  );

  int    checks = 0;
  int    fails  = 0;
  string req    = "R1";
  int    n_sop, n_valid;

  // ---------------- behavioural reference ----------------
  int  h_s [0:MP];
  bit  h_g [0:MP];
  bit  m_hit [2];
  bit  m_prev [2];
  bit  [NE-1:0] m_ext;
  int  m_r;
  int  m_thr [2];
  bit  m_above [2];
  bit  m_edge [2];
  bit  [NS-1:0] m_mask;
  int  m_P, m_L;
  bit  m_rt;
  bit  m_loaded;
  bit  e_v, e_s, e_e;
  int  e_d;

  task automatic model_reset();
    for (int j = 0; j <= MP; j++) begin h_s[j] = 0; h_g[j] = 0; end
    for (int u = 0; u < 2; u++) begin
      m_hit[u] = 0; m_prev[u] = 1; m_thr[u] = 0; m_above[u] = 0; m_edge[u] = 0;
    end
    m_ext = '0; m_r = 0; m_mask = '0; m_P = 0; m_L = 0; m_rt = 0;
    e_v = 0; e_s = 0; e_e = 0; e_d = 0;
  endtask

  // Models the coming clock edge from the inputs now being driven.
  task automatic model_step();
    bit t, acc, emit, sat;
    int rn, x;
    bit [NS-1:0] src;
    src  = {m_ext, m_hit[1], m_hit[0]};
    t    = |(src & m_mask);
    acc  = t && (m_rt || m_r <= m_P);
    emit = acc || (m_r > 0);
    rn   = acc ? (m_P + m_L) : ((m_r > 0) ? m_r - 1 : 0);
    e_v  = emit && h_g[m_P];
    e_s  = emit && (m_r == 0) && h_g[m_P];
    e_e  = emit && (rn == 0) && h_g[m_P];
    if (e_v) e_d = h_s[m_P];
    x = int'(s_x);
    for (int u = 0; u < 2; u++) begin
      sat       = m_above[u] ? (x > m_thr[u]) : (x < m_thr[u]);
      m_hit[u]  = m_edge[u] ? (sat && !m_prev[u]) : sat;
      m_prev[u] = sat;
    end
    m_loaded = 0;
    if (s_load && !emit) begin
      m_loaded   = 1;
      m_thr[0]   = int'(c_thr0);  m_thr[1]   = int'(c_thr1);
      m_above[0] = c_above[0];    m_above[1] = c_above[1];
      m_edge[0]  = c_edge[0];     m_edge[1]  = c_edge[1];
      m_mask     = c_mask;
      m_P        = (int'(c_pre) > MP) ? MP : int'(c_pre);
      m_L        = int'(c_len);
      m_rt       = c_rt;
    end
    m_r   = rn;
    m_ext = s_ext;
    for (int j = MP; j > 0; j--) begin h_s[j] = h_s[j-1]; h_g[j] = h_g[j-1]; end
    h_s[0] = x; h_g[0] = s_g;
  endtask

  task automatic compare();
    bit bad;
    checks++;
    bad = (wr_valid !== e_v) || (wr_sop !== e_s) || (wr_eop !== e_e) ||
          (e_v && (int'(wr_data) != e_d));
    if (bad) begin
      fails++;
      $display("FAIL %s: v/sop/eop/data got %b %b %b %0d exp %b %b %b %0d",
               req, wr_valid, wr_sop, wr_eop, int'(wr_data), e_v, e_s, e_e, e_d);
    end
    if (wr_sop === 1'b1)   n_sop++;
    if (wr_valid === 1'b1) n_valid++;
  endtask

  task automatic drive(int x, bit g, bit [NE-1:0] ext, bit load);
    @(negedge clk);
    compare();
    s_x = SW'(x); s_g = g; s_ext = ext; s_load = load;
    model_step();
  endtask

  task automatic configure(int t0, int t1, bit [1:0] ab, bit [1:0] ed,
                           bit [NS-1:0] mk, int pre, int len, bit rt);
    int guard;
    c_thr0 = SW'(t0); c_thr1 = SW'(t1); c_above = ab; c_edge = ed;
    c_mask = mk; c_pre = 3'(pre); c_len = LW'(len); c_rt = rt;
    guard = 0;
    do begin
      drive(0, 1, '0, 1);
      guard++;
    end while (!m_loaded && guard < 100);
    drive(0, 1, '0, 0);
  endtask

  function automatic bit [NE-1:0] rnd_ext(int div);
    bit [NE-1:0] v;
    v = '0;
    if (div > 0) for (int i = 0; i < NE; i++) v[i] = ($urandom_range(div - 1) == 0);
    return v;
  endfunction

  task automatic run_random(int n, int lo, int hi, int ext_div, int gate_div);
    bit g;
    for (int i = 0; i < n; i++) begin
      g = (gate_div == 0) ? 1'b1 : ($urandom_range(gate_div - 1) != 0);
      drive(lo + int'($urandom_range(hi - lo)), g, rnd_ext(ext_div), 0);
    end
  endtask

  task automatic expect_count(string r, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: %s got %0d expected %0d", r, what, got, exp);
    end
  endtask

  initial begin
    rst_n = 0; s_x = '0; s_g = 0; s_ext = '0; s_load = 0;
    c_thr0 = '0; c_thr1 = '0; c_above = '0; c_edge = '0; c_mask = '0;
    c_pre = '0; c_len = '0; c_rt = 0;
    model_reset();
    repeat (3) @(negedge clk);
    req = "R1";
    compare();
    rst_n = 1;
    for (int i = 0; i < 20; i++) drive(int'($urandom_range(255)) - 128, 1, '0, 0);

    req = "R2";   // unit 0 above 20, level, no retrigger
    configure(20, 0, 2'b01, 2'b00, 9'b000000001, 3, 4, 0);
    run_random(300, -40, 40, 0, 0);

    req = "R3";   // unit 0 below -10, edge
    configure(-10, 0, 2'b00, 2'b01, 9'b000000001, 6, 5, 0);
    run_random(300, -30, 30, 0, 0);

    req = "R7";   // both units, level, retrigger
    configure(25, -25, 2'b01, 2'b00, 9'b000000011, 2, 3, 1);
    run_random(300, -40, 40, 0, 0);

    req = "R5";   // external sources, precursor above depth
    configure(0, 0, 2'b00, 2'b00, 9'b101010100, 7, 2, 0);
    run_random(300, -128, 127, 20, 0);

    req = "R4";   // all sources, edge on unit 1, retrigger
    configure(0, 30, 2'b10, 2'b10, 9'b111111111, 4, 6, 1);
    run_random(300, -60, 60, 60, 0);

    req = "R9";   // random gate
    configure(10, 0, 2'b01, 2'b00, 9'b000000101, 5, 3, 0);
    run_random(400, -40, 40, 30, 3);

    req = "R10";  // one-sample windows
    configure(0, 0, 2'b01, 2'b01, 9'b000000001, 0, 0, 0);
    run_random(300, -10, 10, 0, 0);

    req = "R11";  // load attempts during a window are discarded
    configure(0, 0, 2'b00, 2'b00, 9'b000000100, 3, 8, 0);
    drive(5, 1, 7'b0000001, 0);
    c_pre = 3'd0; c_len = 4'd1; c_mask = 9'b111111111;
    for (int i = 0; i < 6; i++) drive(i, 1, '0, 1);
    for (int i = 0; i < 20; i++) drive(i, 1, '0, 0);
    expect_count("R11", m_P, 3, "precursor after busy load");

    req = "R8";   // trigger 5 samples after a P=4,L=2 trigger: joined packet
    configure(0, 0, 2'b00, 2'b00, 9'b000000100, 4, 2, 0);
    for (int i = 0; i < 10; i++) drive(i, 1, '0, 0);
    n_sop = 0; n_valid = 0;
    drive(50, 1, 7'b0000001, 0);
    for (int i = 0; i < 4; i++) drive(51 + i, 1, '0, 0);
    drive(60, 1, 7'b0000001, 0);
    for (int i = 0; i < 20; i++) drive(70 + i, 1, '0, 0);
    expect_count("R8", n_sop, 1, "packets");
    expect_count("R8", n_valid, 12, "samples written");

    req = "R6";   // edge above 0, P=2,L=3: two rising edges 2 apart, one packet of 6
    configure(0, 0, 2'b01, 2'b01, 9'b000000001, 2, 3, 0);
    for (int i = 0; i < 10; i++) drive(-5, 1, '0, 0);
    n_sop = 0; n_valid = 0;
    drive(9, 1, '0, 0); drive(-9, 1, '0, 0); drive(9, 1, '0, 0);
    for (int i = 0; i < 20; i++) drive(-5, 1, '0, 0);
    expect_count("R6", n_sop, 1, "packets");
    expect_count("R6", n_valid, 6, "samples written");

    req = "R7";   // same stimulus with retrigger: 8 samples
    configure(0, 0, 2'b01, 2'b01, 9'b000000001, 2, 3, 1);
    for (int i = 0; i < 10; i++) drive(-5, 1, '0, 0);
    n_sop = 0; n_valid = 0;
    drive(9, 1, '0, 0); drive(-9, 1, '0, 0); drive(9, 1, '0, 0);
    for (int i = 0; i < 20; i++) drive(-5, 1, '0, 0);
    expect_count("R7", n_valid, 8, "samples written");

    req = "R2";   // equality never fires
    configure(10, 0, 2'b01, 2'b00, 9'b000000001, 1, 1, 0);
    n_valid = 0;
    for (int i = 0; i < 30; i++) drive(10, 1, '0, 0);
    expect_count("R2", n_valid, 0, "writes at threshold");
    drive(11, 1, '0, 0);
    for (int i = 0; i < 10; i++) drive(10, 1, '0, 0);
    expect_count("R2", n_valid, 3, "writes after one crossing");

    @(negedge clk);
    compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule